// File: doc/BRIEF.md
# Microcode State Sequencer

This block steps a serial machine through the microinstructions of the instruction it is running. One microinstruction is performed in each 18-bit short-word period. A small state counter says which step of the instruction is in progress. The counter moves only when the end-of-cycle strobe marks the last bit time of a short word and the enable input is high.

The 10-bit microcode address is formed from three parts. The opcode is the top five bits, the length bit sits below it, and the state counter fills the bottom four bits. Each opcode and length pair therefore owns a slot of 16 consecutive microinstructions. The address selects a 32-bit control word from an internal table. One bit of that word marks the final step of an instruction. At the next boundary that bit sends the counter back to zero, so the following instruction starts at its first step.

Outside logic can zero the counter directly. It can also load the counter with a branch target, which lets a microinstruction jump within its own slot. The table contents are a computed test pattern that stands in for real microcode.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n_i` is low the state counter is zero, so `uaddr_o[3:0]` reads 0 after reset.
- R2: `uaddr_o` is combinational and equals {`opcode_i` in bits 9:5, `long_i` in bit 4, state counter in bits 3:0}.
- R3: The state counter changes only at a rising clock edge where `eoc_i` and `enable_i` are both high. At every other edge it holds, whatever the load and branch inputs are.
- R4: At a step with no zero request, no branch and no end-of-instruction, the state increments modulo 16, so 15 is followed by 0.
- R5: At a step with `br_load_i` high, and with no zero request or end-of-instruction, the state takes the value of `br_state_i`.
- R6: At a step with `load_zero_i` high, the state becomes 0. This takes priority over a branch load.
- R7: `ctrl_o` is the table word for `uaddr_o` (call it a). Bits 9:0 are a, bits 19:10 are ~a, bit 20 is the XOR of all bits of a, bits 30:21 are a, and bit 31 is the end-of-instruction bit.
- R8: Bit 31 of `ctrl_o` is 1 exactly when the state equals {`long_i`, `opcode_i[2:0]`}. `eoi_o` equals that bit.
- R9: At a step where `eoi_o` is high, the state becomes 0. This takes priority over a branch load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| eoc_i | input | 1 | End-of-short-word strobe, high in the last bit time |
| enable_i | input | 1 | Allows the state counter to change |
| load_zero_i | input | 1 | Request to zero the state counter at the next step |
| br_load_i | input | 1 | Microbranch strobe |
| br_state_i | input | 4 | Microbranch target state |
| opcode_i | input | 5 | Opcode of the current instruction |
| long_i | input | 1 | Length bit of the current instruction |
| uaddr_o | output | 10 | Microcode address |
| ctrl_o | output | 32 | Control word for the current address |
| eoi_o | output | 1 | End-of-instruction flag |

## Verification
Some rules are checked by the assertions on every cycle:
- the address is packed correctly;
- the state holds between short-word boundaries;
- an unqualified step increments the state;
- a branch loads the state;
- a zero request or end-of-instruction clears the state;
- `eoi_o` follows its control-word bit.

Other behaviour is shown only by the bench's scenarios: the table pattern itself, the position of the terminal state within each slot, the wrap from 15 to 0, and the full priority order when zero, branch and end-of-instruction meet at one boundary.

// File: rtl/useq_pkg.sv
// Package: shared types for the microcode state sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package useq_pkg;
    // Action applied to the state counter at a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ZERO = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_INC  = 2'd3
    } useq_act_e;
endpackage

// File: rtl/useq_step_ctrl.sv
// Module: useq_step_ctrl
// Chooses what the state counter does at the next edge. A step happens only
// when the end-of-cycle strobe and the enable input are both high. A clear
// request beats a branch load, and a branch load beats an increment.
// Assumes: clear_i already combines the zero request with end-of-instruction.
module useq_step_ctrl
    import useq_pkg::*;
(
    input  logic      eoc_i,
    input  logic      enable_i,
    input  logic      clear_i,
    input  logic      br_load_i,
    output useq_act_e act_o
);
    logic step;

    assign step = eoc_i & enable_i;

    // Priority selection of the counter action
    always_comb begin
        if (!step)          act_o = ACT_HOLD;
        else if (clear_i)   act_o = ACT_ZERO;
        else if (br_load_i) act_o = ACT_LOAD;
        else                act_o = ACT_INC;
    end
endmodule

// File: rtl/useq_state_ctr.sv
// Module: useq_state_ctr
// Holds the microinstruction state number and applies the chosen action.
// Assumes: the reset is synchronous and active low, and the increment wraps.
module useq_state_ctr
    import useq_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  useq_act_e          act_i,
    input  logic [STATE_W-1:0] br_state_i,
    output logic [STATE_W-1:0] state_o
);
    logic [STATE_W-1:0] state_q;

    // State register update
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= '0;
        end else begin
            unique case (act_i)
                ACT_ZERO: state_q <= '0;
                ACT_LOAD: state_q <= br_state_i;
                ACT_INC:  state_q <= state_q + 1'b1;
                default:  state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/useq_table.sv
// Module: useq_table
// Stands in for the microcode table. It computes a test word from the address.
// The end-of-instruction bit is set where the state field equals the length
// bit followed by the low opcode bits. The other bits repeat the address, its
// inverse and its parity.
// Assumes: STATE_W >= 2 and OP_W >= STATE_W-1.
module useq_table #(
    parameter int OP_W    = 5,
    parameter int STATE_W = 4,
    parameter int CW_W    = 32,
    parameter int EOI_BIT = 31,
    localparam int ADDR_W = OP_W + 1 + STATE_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CW_W-1:0]   word_o
);
    logic [STATE_W-1:0] st_f;
    logic               len_f;
    logic [OP_W-1:0]    op_f;
    logic               term;

    assign st_f  = addr_i[STATE_W-1:0];
    assign len_f = addr_i[STATE_W];
    assign op_f  = addr_i[ADDR_W-1:STATE_W+1];
    assign term  = (st_f == {len_f, op_f[STATE_W-2:0]});

    // Assemble the test word bit by bit
    always_comb begin
        word_o = '0;
        for (int i = 0; i < CW_W; i++) begin
            if (i == EOI_BIT)          word_o[i] = term;
            else if (i < ADDR_W)       word_o[i] = addr_i[i];
            else if (i < 2 * ADDR_W)   word_o[i] = ~addr_i[i - ADDR_W];
            else if (i == 2 * ADDR_W)  word_o[i] = ^addr_i;
            else                       word_o[i] = addr_i[(i - 2 * ADDR_W - 1) % ADDR_W];
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
// Module: useq_sequencer (top)
// Microcode state sequencer. It forms {opcode, length, state} as the microcode
// address, reads the control word for that address, and steps the state once
// per short word. The end-of-instruction bit of the word forces the state back
// to zero.
// Assumes: eoc_i is high for exactly one clock per short word.
module useq_sequencer #(
    parameter int OP_W    = 5,
    parameter int STATE_W = 4,
    parameter int CW_W    = 32,
    parameter int EOI_BIT = 31,
    localparam int ADDR_W = OP_W + 1 + STATE_W
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               eoc_i,
    input  logic               enable_i,
    input  logic               load_zero_i,
    input  logic               br_load_i,
    input  logic [STATE_W-1:0] br_state_i,
    input  logic [OP_W-1:0]    opcode_i,
    input  logic               long_i,
    output logic [ADDR_W-1:0]  uaddr_o,
    output logic [CW_W-1:0]    ctrl_o,
    output logic               eoi_o
);
    import useq_pkg::*;

    useq_act_e          act;
    logic [STATE_W-1:0] state;
    logic               eoi;

    // Action selection; end-of-instruction joins the zero request
    useq_step_ctrl u_ctl (
        .eoc_i     (eoc_i),
        .enable_i  (enable_i),
        .clear_i   (load_zero_i | eoi),
        .br_load_i (br_load_i),
        .act_o     (act)
    );

    // State register
    useq_state_ctr #(.STATE_W(STATE_W)) u_ctr (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .act_i      (act),
        .br_state_i (br_state_i),
        .state_o    (state)
    );

    assign uaddr_o = {opcode_i, long_i, state};

    // Control word lookup
    useq_table #(
        .OP_W(OP_W), .STATE_W(STATE_W), .CW_W(CW_W), .EOI_BIT(EOI_BIT)
    ) u_tbl (
        .addr_i (uaddr_o),
        .word_o (ctrl_o)
    );

    assign eoi   = ctrl_o[EOI_BIT];
    assign eoi_o = eoi;
endmodule

// File: rtl/useq_sequencer_chk.sv
// Module: useq_sequencer_chk
// Checker bound to useq_sequencer. It watches only the ports.
// Assumes: the state counter is visible as the low bits of uaddr_o.
module useq_sequencer_chk #(
    parameter int OP_W    = 5,
    parameter int STATE_W = 4,
    parameter int CW_W    = 32,
    parameter int EOI_BIT = 31,
    localparam int ADDR_W = OP_W + 1 + STATE_W
) (
    input logic               clk_i,
    input logic               rst_n_i,
    input logic               eoc_i,
    input logic               enable_i,
    input logic               load_zero_i,
    input logic               br_load_i,
    input logic [STATE_W-1:0] br_state_i,
    input logic [OP_W-1:0]    opcode_i,
    input logic               long_i,
    input logic [ADDR_W-1:0]  uaddr_o,
    input logic [CW_W-1:0]    ctrl_o,
    input logic               eoi_o
);
    logic [STATE_W-1:0] st;
    logic               step;

    assign st   = uaddr_o[STATE_W-1:0];
    assign step = eoc_i && enable_i;

    // R2: the opcode and length fields pass straight into the address
    always_comb begin
        if (rst_n_i) begin
            a_r2_addr_fields: assert (uaddr_o[ADDR_W-1:STATE_W] == {opcode_i, long_i});
        end
    end

    // R8: the flag port follows its control-word bit
    always_comb begin
        if (rst_n_i) begin
            a_r8_eoi_flag: assert (eoi_o == ctrl_o[EOI_BIT]);
        end
    end

    // R3: no step means the state holds
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !step |=> st == $past(st));

    // R4: a plain step increments the state
    a_r4_increment: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        step && !load_zero_i && !br_load_i && !eoi_o |=> st == STATE_W'($past(st) + 1'b1));

    // R5: a branch step loads the target
    a_r5_branch: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        step && !load_zero_i && br_load_i && !eoi_o |=> st == $past(br_state_i));

    // R6: a zero request clears the state
    a_r6_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        step && load_zero_i |=> st == '0);

    // R9: end-of-instruction clears the state
    a_r9_eoi_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        step && eoi_o |=> st == '0);
endmodule

bind useq_sequencer useq_sequencer_chk #(
    .OP_W(OP_W), .STATE_W(STATE_W), .CW_W(CW_W), .EOI_BIT(EOI_BIT)
) u_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .eoc_i(eoc_i), .enable_i(enable_i),
    .load_zero_i(load_zero_i), .br_load_i(br_load_i), .br_state_i(br_state_i),
    .opcode_i(opcode_i), .long_i(long_i), .uaddr_o(uaddr_o), .ctrl_o(ctrl_o),
    .eoi_o(eoi_o)
);

// File: tb/useq_sequencer_bench.sv
// Bench: directed scenarios for useq_sequencer, one task for each scenario.
module useq_sequencer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc = 1'b0, en = 1'b0, lz = 1'b0, brl = 1'b0;
    logic [3:0]  brv = '0;
    logic [4:0]  op = '0;
    logic        lng = 1'b0;
    logic [9:0]  uaddr;
    logic [31:0] ctrl;
    logic        eoi;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [3:0] exp_st = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk_i(clk), .rst_n_i(rst_n), .eoc_i(eoc), .enable_i(en),
        .load_zero_i(lz), .br_load_i(brl), .br_state_i(brv),
        .opcode_i(op), .long_i(lng), .uaddr_o(uaddr), .ctrl_o(ctrl), .eoi_o(eoi)
    );

    // Expected word from the R7 and R8 layout
    function automatic logic [31:0] exp_word(input logic [9:0] a);
        logic t;
        t = (a[3:0] == {a[4], a[7:5]});
        return {t, a, ^a, ~a, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Check the address, the word and the flag against the model
    task automatic chk_outputs(input string req);
        logic [9:0] a;
        a = {op, lng, exp_st};
        chk(req, {22'd0, uaddr}, {22'd0, a});
        chk({req, "/R7"}, ctrl, exp_word(a));
        chk({req, "/R8"}, {31'd0, eoi}, {31'd0, exp_word(a)[31]});
    endtask

    // Apply one clock with the given controls, update the model, then check
    task automatic cyc(input logic e, input logic n, input logic z, input logic b,
                       input logic [3:0] v, input string req);
        logic term;
        eoc = e; en = n; lz = z; brl = b; brv = v;
        term = (exp_st == {lng, op[2:0]});
        @(posedge clk);
        if (e && n) begin
            if (z || term) exp_st = '0;
            else if (b)    exp_st = v;
            else           exp_st = exp_st + 4'd1;
        end
        #1;
        chk_outputs(req);
        eoc = 1'b0; en = 1'b0; lz = 1'b0; brl = 1'b0;
    endtask

    task automatic set_instr(input logic [4:0] o, input logic l);
        op = o; lng = l;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_instr(5'b10111, 1'b1);
        eoc = 1'b1; en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        exp_st = '0;
        chk("R1 reset state", {28'd0, uaddr[3:0]}, 32'd0);
        eoc = 1'b0; en = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_outputs("R1 after reset");
    endtask

    task automatic t_addr_map();
        set_instr(5'b10110, 1'b0);
        chk_outputs("R2 fields a");
        set_instr(5'b01001, 1'b1);
        chk_outputs("R2 fields b");
        set_instr(5'b11111, 1'b1);
        chk_outputs("R2 fields c");
    endtask

    task automatic t_hold();
        set_instr(5'b10111, 1'b1);  // terminal state 15
        cyc(1, 1, 0, 0, 4'd0, "R4 step to 1");
        cyc(1, 0, 1, 1, 4'd9, "R3 strobe without enable");
        cyc(0, 1, 1, 1, 4'd9, "R3 enable without strobe");
        cyc(0, 0, 0, 0, 4'd0, "R3 idle");
        chk("R3 held at 1", {28'd0, uaddr[3:0]}, 32'd1);
    endtask

    task automatic t_count();
        set_instr(5'b00111, 1'b1);  // terminal state 15
        for (int i = 0; i < 13; i++) cyc(1, 1, 0, 0, 4'd0, "R4 increment");
        chk("R4 reached 14", {28'd0, uaddr[3:0]}, 32'd14);
        set_instr(5'b00011, 1'b0);  // terminal state 3, so 15 is not terminal
        cyc(1, 1, 0, 1, 4'd15, "R5 branch to 15");
        cyc(1, 1, 0, 0, 4'd0, "R4 wrap 15 to 0");
        chk("R4 wrap", {28'd0, uaddr[3:0]}, 32'd0);
    endtask

    task automatic t_branch();
        set_instr(5'b00110, 1'b1);  // terminal state 14
        cyc(1, 1, 0, 1, 4'd9, "R5 branch to 9");
        chk("R5 at 9", {28'd0, uaddr[3:0]}, 32'd9);
        cyc(1, 1, 0, 1, 4'd4, "R5 branch to 4");
        chk("R5 at 4", {28'd0, uaddr[3:0]}, 32'd4);
    endtask

    task automatic t_zero_priority();
        set_instr(5'b00110, 1'b1);
        cyc(1, 1, 0, 0, 4'd0, "R4 step");
        cyc(1, 1, 1, 1, 4'd11, "R6 zero beats branch");
        chk("R6 zeroed", {28'd0, uaddr[3:0]}, 32'd0);
        cyc(1, 1, 0, 0, 4'd0, "R4 step");
        cyc(1, 1, 1, 0, 4'd0, "R6 zero");
        chk("R6 zeroed alone", {28'd0, uaddr[3:0]}, 32'd0);
    endtask

    task automatic t_eoi();
        set_instr(5'b11010, 1'b0);  // terminal state 2
        cyc(1, 1, 0, 0, 4'd0, "R4 to 1");
        chk("R8 not terminal at 1", {31'd0, eoi}, 32'd0);
        cyc(1, 1, 0, 0, 4'd0, "R4 to 2");
        chk("R8 terminal at 2", {31'd0, eoi}, 32'd1);
        cyc(1, 1, 0, 1, 4'd7, "R9 eoi beats branch");
        chk("R9 cleared", {28'd0, uaddr[3:0]}, 32'd0);
        set_instr(5'b00000, 1'b0);  // terminal state 0
        chk("R8 terminal at 0", {31'd0, eoi}, 32'd1);
        cyc(1, 1, 0, 0, 4'd0, "R9 stays at 0");
        chk("R9 held at 0", {28'd0, uaddr[3:0]}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_addr_map();
        t_hold();
        t_count();
        t_branch();
        t_zero_priority();
        t_eoi();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule